// File: doc/BRIEF.md
# IO Address Translation Unit

This block sits between DMA-capable devices and system memory and turns each device-issued IO address into a physical address. The IO space is cut into 256 MB segments. The upper address bits pick an entry in a segment table in memory. That entry points at a page table and sets the page size for the segment. The page index then selects a 64-bit page entry, which holds the real page number and the read and write permissions.

The block handles one request at a time. It accepts a request, fetches the two entries over a simple request/response memory port, and returns either the physical address or a fault.

A small register interface lets software do four things:
- set the table origin,
- switch translation on,
- read and acknowledge the fault record,
- choose which fault kinds raise the interrupt line.

When translation is switched off, addresses pass through unchanged.

Top module: `iox_xlate_unit`

## Requirements
- R1: Translation is active only when origin register bit 63 and config register bit 47 are both 1. Otherwise an accepted request is answered in the next cycle with `rsp_addr_o` equal to the zero-extended request address and `rsp_fault_o` low, and no memory fetch is made.
- R2: The segment entry is fetched from address (origin bits 61:12) * 4096 + (request address bits 34:28) * 8. In a segment entry:
  - bit 63 is valid;
  - bits 61:12 are the page-table base page;
  - bits 11:5 are the page-table page count minus one;
  - bits 2:0 are the page size code: 1 = 4 KB, 3 = 64 KB, 5 = 1 MB, 7 = 16 MB.
- R3: The page index is address bits 27:S, where S is 12, 16, 20 or 24 for the four page sizes. The page entry is fetched from base page * 4096 + index * 8. The physical address is entry bits 58:12 shifted left by 12, with its low S bits replaced by the request address bits S-1:0.
- R4: A segment entry with bit 63 clear, or with an even page size code, gives a fault response of kind segment.
- R5: A page index with (index >> 9) greater than the page-count field gives a fault response of kind page, and no page entry is fetched.
- R6: A read needs page entry bit 62 and a write needs bit 63. If the needed bit is missing, the response is a fault of kind page.
- R7: When the status valid bit is clear, a fault loads the status register as follows:
  - bit 63 is set to 1;
  - bits 62:61 hold the kind (11 = segment, 10 = page);
  - bits 34:12 hold address bits 34:12;
  - bit 11 is 1 for a read and 0 for a write;
  - bits 10:0 hold the request IOID.
- R8: While status bit 63 is 1, further faults leave the status register unchanged but still return a fault response.
- R9: A software write to the status register replaces its contents, so writing 0 acknowledges a fault. A fault captured in the same cycle takes precedence.
- R10: `irq_o` is high exactly when status bit 63 is set and the mask bit for the captured kind is set. Mask bit 62 enables segment faults and mask bit 61 enables page faults.
- R11: Only one request is in flight at a time:
  - `req_ready_o` is high only when the block is idle;
  - `rsp_valid_o` is a one-cycle pulse;
  - `mem_req_o` stays high with a stable `mem_addr_o` until `mem_rvalid_i`.
- R12: Register select codes are 0 = origin, 1 = config, 2 = status, 3 = mask. Reads return stored bits only: origin bits 63 and 61:12, config bit 47, status all bits, mask bits 62:61. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | DMA request present |
| req_ready_o | output | 1 | Block idle, request accepted this cycle |
| req_addr_i | input | 35 | IO address |
| req_write_i | input | 1 | 1 = write access, 0 = read |
| req_ioid_i | input | 11 | Requesting device ID |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_fault_o | output | 1 | Response is a fault |
| rsp_addr_o | output | 59 | Physical address (0 on fault) |
| mem_req_o | output | 1 | Table entry fetch pending |
| mem_addr_o | output | 62 | Byte address of the entry |
| mem_rvalid_i | input | 1 | Fetch data returned |
| mem_rdata_i | input | 64 | Fetched entry |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data (combinational) |
| irq_o | output | 1 | Fault interrupt, level |

## Verification
The walk is driven with a small set of address patterns, and each pattern singles out one path.

- **Successful translations.** A 4 KB read and a 4 KB write hit one page entry. A 64 KB read hits another. Together they show that the index shift and the offset merge depend on the page-size code.
- **Faults.** An empty segment gives a segment fault. An index past the page count gives a page fault. A page with no permission gives a page fault. A write to a read-only page gives a page fault. The exact status word and the fetch count tell these fault sources apart.
- **Sticky status and interrupt.** A second fault while the status is held shows that the record is kept. Toggling each mask bit shows that the interrupt is selected by fault kind.
- **Enable gating.** Pass-through requests with one or both enable bits clear confirm that both enables are required.

// File: rtl/iox_pkg.sv
package iox_pkg;
  localparam int unsigned SEG_SHIFT    = 28;
  localparam int unsigned PG_MIN_SHIFT = 12;
  localparam int unsigned ENT_LG       = 9;   // 512 entries per 4 KB table page
  localparam int unsigned IOID_W       = 11;
  localparam int unsigned CFG_TE_BIT   = 47;

  typedef enum logic [1:0] {
    SEL_ORIGIN = 2'd0,
    SEL_CONFIG = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_MASK   = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    FK_NONE = 2'b00,
    FK_PAGE = 2'b10,
    FK_SEG  = 2'b11
  } fault_kind_e;
endpackage

// File: rtl/iox_regs.sv
module iox_regs
  import iox_pkg::*;
#(
  parameter int unsigned IOVA_W = 35,
  parameter int unsigned MEM_AW = 62
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_we_i,
  input  logic [1:0]              reg_sel_i,
  input  logic [63:0]             reg_wdata_i,
  output logic [63:0]             reg_rdata_o,
  input  logic                    flt_i,
  input  fault_kind_e             flt_kind_i,
  input  logic [IOVA_W-1:0]       flt_va_i,
  input  logic                    flt_rd_i,
  input  logic [IOID_W-1:0]       flt_ioid_i,
  output logic                    xlate_en_o,
  output logic [MEM_AW-13:0]      tbl_page_o,
  output logic [63:0]             stat_o,
  output logic                    irq_o
);
  localparam int unsigned PN_W  = MEM_AW - PG_MIN_SHIFT;
  localparam int unsigned VPN_W = IOVA_W - PG_MIN_SHIFT;

  logic            org_en_q;
  logic [PN_W-1:0] org_page_q;
  logic            te_q;
  logic [63:0]     stat_q;
  logic            msk_seg_q, msk_pg_q;
  logic [63:0]     cap;
  reg_sel_e        sel;

  assign sel = reg_sel_e'(reg_sel_i);

  always_comb begin
    cap = '0;
    cap[63] = 1'b1;
    cap[62:61] = flt_kind_i;
    cap[PG_MIN_SHIFT +: VPN_W] = flt_va_i[IOVA_W-1:PG_MIN_SHIFT];
    cap[11] = flt_rd_i;
    cap[10:0] = flt_ioid_i;
  end

  logic [PG_MIN_SHIFT-1:0] unused_va;
  assign unused_va = flt_va_i[PG_MIN_SHIFT-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      org_en_q   <= 1'b0;
      org_page_q <= '0;
      te_q       <= 1'b0;
      stat_q     <= '0;
      msk_seg_q  <= 1'b0;
      msk_pg_q   <= 1'b0;
    end else begin
      if (reg_we_i) begin
        unique case (sel)
          SEL_ORIGIN: begin
            org_en_q   <= reg_wdata_i[63];
            org_page_q <= reg_wdata_i[PG_MIN_SHIFT +: PN_W];
          end
          SEL_CONFIG: te_q <= reg_wdata_i[CFG_TE_BIT];
          SEL_MASK: begin
            msk_seg_q <= reg_wdata_i[62];
            msk_pg_q  <= reg_wdata_i[61];
          end
          default: ;
        endcase
      end
      // capture of a new fault wins over a same-cycle software write
      if (flt_i && !stat_q[63]) stat_q <= cap;
      else if (reg_we_i && sel == SEL_STATUS) stat_q <= reg_wdata_i;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      SEL_ORIGIN: begin
        reg_rdata_o[63] = org_en_q;
        reg_rdata_o[PG_MIN_SHIFT +: PN_W] = org_page_q;
      end
      SEL_CONFIG: reg_rdata_o[CFG_TE_BIT] = te_q;
      SEL_STATUS: reg_rdata_o = stat_q;
      SEL_MASK: begin
        reg_rdata_o[62] = msk_seg_q;
        reg_rdata_o[61] = msk_pg_q;
      end
      default: ;
    endcase
  end

  assign xlate_en_o = org_en_q & te_q;
  assign tbl_page_o = org_page_q;
  assign stat_o     = stat_q;
  assign irq_o      = stat_q[63] & stat_q[62] &
                      ((stat_q[61] & msk_seg_q) | (!stat_q[61] & msk_pg_q));
endmodule

// File: rtl/iox_walk.sv
module iox_walk
  import iox_pkg::*;
#(
  parameter int unsigned IOVA_W = 35,
  parameter int unsigned PA_W   = 59,
  parameter int unsigned MEM_AW = 62
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    xlate_en_i,
  input  logic [MEM_AW-13:0]      tbl_page_i,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [IOVA_W-1:0]       req_addr_i,
  input  logic                    req_write_i,
  input  logic [IOID_W-1:0]       req_ioid_i,
  output logic                    rsp_valid_o,
  output logic                    rsp_fault_o,
  output logic [PA_W-1:0]         rsp_addr_o,
  output logic                    mem_req_o,
  output logic [MEM_AW-1:0]       mem_addr_o,
  input  logic                    mem_rvalid_i,
  input  logic [63:0]             mem_rdata_i,
  output logic                    flt_o,
  output fault_kind_e             flt_kind_o,
  output logic [IOVA_W-1:0]       flt_va_o,
  output logic                    flt_rd_o,
  output logic [IOID_W-1:0]       flt_ioid_o
);
  localparam int unsigned SEG_W = IOVA_W - SEG_SHIFT;

  typedef enum logic [1:0] {ST_IDLE, ST_STE, ST_PTE, ST_RSP} walk_st_e;

  walk_st_e           st_q;
  logic [IOVA_W-1:0]  va_q;
  logic               wr_q;
  logic [IOID_W-1:0]  ioid_q;
  logic [MEM_AW-1:0]  addr_q;
  logic [4:0]         shift_q;
  logic [PA_W-1:0]    pa_q;
  logic               flt_q;

  // segment entry decode
  logic               ste_ok, over;
  logic [4:0]         ste_shift;
  logic [SEG_SHIFT-1:0] pg_idx;
  logic [MEM_AW-1:0]  pte_addr, seg_addr;
  // page entry decode
  logic               perm_ok;
  logic [PA_W-1:0]    pg_mask, pa_xl;

  always_comb begin
    ste_ok    = mem_rdata_i[63] & mem_rdata_i[0];
    ste_shift = 5'(PG_MIN_SHIFT) + {1'b0, mem_rdata_i[2:1], 2'b00};
    pg_idx    = va_q[SEG_SHIFT-1:0] >> ste_shift;
    over      = (pg_idx >> ENT_LG) > SEG_SHIFT'(mem_rdata_i[11:5]);
    pte_addr  = {mem_rdata_i[MEM_AW-1:PG_MIN_SHIFT], 12'b0} + MEM_AW'({pg_idx, 3'b000});
    seg_addr  = {tbl_page_i, 12'b0} + MEM_AW'({req_addr_i[IOVA_W-1 -: SEG_W], 3'b000});
    perm_ok   = wr_q ? mem_rdata_i[63] : mem_rdata_i[62];
    pg_mask   = (PA_W'(1) << shift_q) - PA_W'(1);
    pa_xl     = ({mem_rdata_i[PA_W-1:PG_MIN_SHIFT], 12'b0} & ~pg_mask) |
                (PA_W'(va_q) & pg_mask);
  end

  logic unused_bits;
  assign unused_bits = ^{mem_rdata_i[62], mem_rdata_i[4:3]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      ioid_q  <= '0;
      addr_q  <= '0;
      shift_q <= '0;
      pa_q    <= '0;
      flt_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          va_q   <= req_addr_i;
          wr_q   <= req_write_i;
          ioid_q <= req_ioid_i;
          if (xlate_en_i) begin
            addr_q <= seg_addr;
            st_q   <= ST_STE;
          end else begin
            pa_q  <= PA_W'(req_addr_i);
            flt_q <= 1'b0;
            st_q  <= ST_RSP;
          end
        end
        ST_STE: if (mem_rvalid_i) begin
          if (!ste_ok || over) begin
            flt_q <= 1'b1;
            pa_q  <= '0;
            st_q  <= ST_RSP;
          end else begin
            addr_q  <= pte_addr;
            shift_q <= ste_shift;
            st_q    <= ST_PTE;
          end
        end
        ST_PTE: if (mem_rvalid_i) begin
          flt_q <= !perm_ok;
          pa_q  <= perm_ok ? pa_xl : '0;
          st_q  <= ST_RSP;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign rsp_valid_o = (st_q == ST_RSP);
  assign rsp_fault_o = flt_q;
  assign rsp_addr_o  = pa_q;
  assign mem_req_o   = (st_q == ST_STE) || (st_q == ST_PTE);
  assign mem_addr_o  = addr_q;

  assign flt_o      = mem_rvalid_i &&
                      ((st_q == ST_STE && (!ste_ok || over)) ||
                       (st_q == ST_PTE && !perm_ok));
  assign flt_kind_o = (st_q == ST_STE && !ste_ok) ? FK_SEG : FK_PAGE;
  assign flt_va_o   = va_q;
  assign flt_rd_o   = !wr_q;
  assign flt_ioid_o = ioid_q;
endmodule

// File: rtl/iox_xlate_unit.sv
module iox_xlate_unit
  import iox_pkg::*;
#(
  parameter int unsigned IOVA_W = 35,
  parameter int unsigned PA_W   = 59,
  parameter int unsigned MEM_AW = 62
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [IOVA_W-1:0]       req_addr_i,
  input  logic                    req_write_i,
  input  logic [IOID_W-1:0]       req_ioid_i,
  output logic                    rsp_valid_o,
  output logic                    rsp_fault_o,
  output logic [PA_W-1:0]         rsp_addr_o,
  output logic                    mem_req_o,
  output logic [MEM_AW-1:0]       mem_addr_o,
  input  logic                    mem_rvalid_i,
  input  logic [63:0]             mem_rdata_i,
  input  logic                    reg_we_i,
  input  logic [1:0]              reg_sel_i,
  input  logic [63:0]             reg_wdata_i,
  output logic [63:0]             reg_rdata_o,
  output logic                    irq_o
);
  logic                xlate_en;
  logic [MEM_AW-13:0]  tbl_page;
  logic [63:0]         stat_w;
  logic                flt;
  fault_kind_e         flt_kind;
  logic [IOVA_W-1:0]   flt_va;
  logic                flt_rd;
  logic [IOID_W-1:0]   flt_ioid;

  iox_regs #(.IOVA_W(IOVA_W), .MEM_AW(MEM_AW)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_sel_i, .reg_wdata_i, .reg_rdata_o,
    .flt_i(flt), .flt_kind_i(flt_kind), .flt_va_i(flt_va), .flt_rd_i(flt_rd),
    .flt_ioid_i(flt_ioid), .xlate_en_o(xlate_en), .tbl_page_o(tbl_page),
    .stat_o(stat_w), .irq_o
  );

  iox_walk #(.IOVA_W(IOVA_W), .PA_W(PA_W), .MEM_AW(MEM_AW)) u_walk (
    .clk_i, .rst_ni, .xlate_en_i(xlate_en), .tbl_page_i(tbl_page),
    .req_valid_i, .req_ready_o, .req_addr_i, .req_write_i, .req_ioid_i,
    .rsp_valid_o, .rsp_fault_o, .rsp_addr_o,
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .flt_o(flt), .flt_kind_o(flt_kind), .flt_va_o(flt_va), .flt_rd_o(flt_rd),
    .flt_ioid_o(flt_ioid)
  );
endmodule

// File: rtl/iox_xlate_chk.sv
module iox_xlate_chk #(
  parameter int unsigned IOVA_W = 35,
  parameter int unsigned PA_W   = 59,
  parameter int unsigned MEM_AW = 62
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [IOVA_W-1:0] req_addr_i,
  input logic              rsp_valid_o,
  input logic              rsp_fault_o,
  input logic [PA_W-1:0]   rsp_addr_o,
  input logic              mem_req_o,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic              mem_rvalid_i,
  input logic              reg_we_i,
  input logic [1:0]        reg_sel_i,
  input logic              irq_o,
  input logic              xlate_en,
  input logic [63:0]       stat_w
);
  a_r11_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r11_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  a_r11_busy_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  a_r1_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !xlate_en) |=>
      (rsp_valid_o && !rsp_fault_o && rsp_addr_o == PA_W'($past(req_addr_i))));

  a_r10_irq_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_w[63] |-> !irq_o);

  a_r8_sticky_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_w[63] && !(reg_we_i && reg_sel_i == 2'd2)) |=> $stable(stat_w));
endmodule

bind iox_xlate_unit iox_xlate_chk #(.IOVA_W(IOVA_W), .PA_W(PA_W), .MEM_AW(MEM_AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_addr_i(req_addr_i), .rsp_valid_o(rsp_valid_o), .rsp_fault_o(rsp_fault_o),
  .rsp_addr_o(rsp_addr_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .mem_rvalid_i(mem_rvalid_i), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
  .irq_o(irq_o), .xlate_en(xlate_en), .stat_w(stat_w)
);

// File: tb/iox_xlate_unit_test.sv
module iox_xlate_unit_test;
  localparam int IOVA_W = 35, PA_W = 59, MEM_AW = 62;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              req_valid = 0, req_ready, req_write = 0;
  logic [IOVA_W-1:0] req_addr = '0;
  logic [10:0]       req_ioid = '0;
  logic              rsp_valid, rsp_fault;
  logic [PA_W-1:0]   rsp_addr;
  logic              mem_req, mem_rvalid;
  logic [MEM_AW-1:0] mem_addr;
  logic [63:0]       mem_rdata;
  logic              reg_we = 0;
  logic [1:0]        reg_sel = 0;
  logic [63:0]       reg_wdata = '0, reg_rdata;
  logic              irq;

  iox_xlate_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_write_i(req_write), .req_ioid_i(req_ioid),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_addr_o(rsp_addr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  // table memory model: sparse list, unlisted words read 0
  logic [MEM_AW-1:0] m_addr [8];
  logic [63:0]       m_data [8];
  int                fetches = 0;

  function automatic logic [63:0] lookup(input logic [MEM_AW-1:0] a);
    lookup = '0;
    for (int i = 0; i < 8; i++) if (m_addr[i] == a) lookup = m_data[i];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      mem_rvalid <= mem_req && !mem_rvalid;
      mem_rdata  <= lookup(mem_addr);
      if (mem_req && mem_rvalid) fetches <= fetches + 1;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [63:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic xfer(input logic [IOVA_W-1:0] a, input logic w, input logic [10:0] id,
                      output logic flt, output logic [PA_W-1:0] pa, output int lat);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w; req_ioid = id;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (!rsp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    flt = rsp_fault;
    pa = rsp_addr;
  endtask

  task automatic t_reset;
    logic [63:0] d;
    chk("R11 ready after reset", 64'(req_ready), 64'd1);
    chk("R11 no rsp after reset", 64'(rsp_valid), 64'd0);
    chk("R10 irq after reset", 64'(irq), 64'd0);
    rd_reg(2'd2, d); chk("R12 status reset", d, 64'd0);
  endtask

  task automatic t_reg_fields;
    logic [63:0] d;
    wr_reg(2'd1, '1); rd_reg(2'd1, d); chk("R12 config only bit47", d, 64'h0000_8000_0000_0000);
    wr_reg(2'd3, '1); rd_reg(2'd3, d); chk("R12 mask only 62:61", d, 64'h6000_0000_0000_0000);
    wr_reg(2'd0, 64'h7FFF_FFFF_FFFF_FFFF);
    rd_reg(2'd0, d); chk("R12 origin fields", d, 64'h3FFF_FFFF_FFFF_F000);
    wr_reg(2'd3, 64'd0);
  endtask

  task automatic t_passthru(input string tag);
    logic f; logic [PA_W-1:0] pa; int lat, f0;
    f0 = fetches;
    xfer(35'h7_FFFF_F123, 1'b1, 11'h55, f, pa, lat);
    chk({tag, " latency"}, 64'(lat), 64'd1);
    chk({tag, " addr"}, 64'(pa), 64'h7_FFFF_F123);
    chk({tag, " no fault"}, 64'(f), 64'd0);
    chk({tag, " no fetch"}, 64'(fetches - f0), 64'd0);
  endtask

  task automatic t_good(input string tag, input logic [IOVA_W-1:0] a, input logic w,
                        input logic [PA_W-1:0] exp);
    logic f; logic [PA_W-1:0] pa; int lat;
    xfer(a, w, 11'h5, f, pa, lat);
    chk({tag, " fault"}, 64'(f), 64'd0);
    chk({tag, " addr"}, 64'(pa), 64'(exp));
  endtask

  task automatic t_bad(input string tag, input logic [IOVA_W-1:0] a, input logic w,
                       input logic [10:0] id, input logic [63:0] exp_stat,
                       input logic exp_irq, input int exp_fetch);
    logic f; logic [PA_W-1:0] pa; int lat, f0; logic [63:0] d;
    f0 = fetches;
    xfer(a, w, id, f, pa, lat);
    chk({tag, " fault rsp"}, 64'(f), 64'd1);
    chk({tag, " fetches"}, 64'(fetches - f0), 64'(exp_fetch));
    rd_reg(2'd2, d); chk({tag, " status"}, d, exp_stat);
    chk({tag, " irq"}, 64'(irq), 64'(exp_irq));
  endtask

  task automatic t_ack;
    logic [63:0] d;
    wr_reg(2'd2, 64'd0);
    rd_reg(2'd2, d); chk("R9 status cleared", d, 64'd0);
    chk("R9 irq drops", 64'(irq), 64'd0);
  endtask

  initial begin
    m_addr[0] = 62'h10000; m_data[0] = 64'h8000_0000_0002_0001; // seg0: 4K, 1 tbl page @0x20
    m_addr[1] = 62'h10010; m_data[1] = 64'h8000_0000_0003_0003; // seg2: 64K @0x30
    m_addr[2] = 62'h20018; m_data[2] = 64'hC000_0000_1234_5000; // idx3 RW
    m_addr[3] = 62'h30028; m_data[3] = 64'h4000_0000_4000_0000; // idx5 R only
    m_addr[4] = 62'h10018; m_data[4] = 64'h8000_0000_0002_0002; // seg3: even size code
    for (int i = 5; i < 8; i++) begin m_addr[i] = '1; m_data[i] = '0; end

    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_reg_fields();
    wr_reg(2'd1, 64'd0);
    wr_reg(2'd0, 64'd0);
    t_passthru("R1 both off");
    wr_reg(2'd0, 64'h8000_0000_0001_0000);
    t_passthru("R1 config off");
    wr_reg(2'd1, 64'h0000_8000_0000_0000);

    t_good("R2 R3 4K read", 35'h0_0000_3ABC, 1'b0, 59'h1234_5ABC);
    t_good("R6 4K write", 35'h0_0000_3010, 1'b1, 59'h1234_5010);
    t_good("R3 64K read", 35'h0_2005_1234, 1'b0, 59'h4000_1234);
    t_bad("R6 R7 write to read-only", 35'h0_2005_1234, 1'b1, 11'h7AB,
          64'hC000_0000_2005_17AB, 1'b0, 2);
    t_bad("R8 held seg fault", 35'h0_1000_0000, 1'b0, 11'h3,
          64'hC000_0000_2005_17AB, 1'b0, 1);
    t_ack();
    wr_reg(2'd3, 64'h4000_0000_0000_0000);
    t_bad("R4 R10 seg fault irq", 35'h0_1000_0000, 1'b0, 11'h3,
          64'hE000_0000_1000_0803, 1'b1, 1);
    t_ack();
    t_bad("R4 even size code", 35'h0_3000_0000, 1'b1, 11'h0,
          64'hE000_0000_3000_0000, 1'b1, 1);
    t_ack();
    t_bad("R10 page fault masked", 35'h0_0000_4000, 1'b0, 11'h0,
          64'hC000_0000_0000_4800, 1'b0, 2);
    t_ack();
    wr_reg(2'd3, 64'h2000_0000_0000_0000);
    t_bad("R5 beyond count", 35'h0_0025_8000, 1'b0, 11'h1,
          64'hC000_0000_0025_8801, 1'b1, 1);
    t_ack();
    t_bad("R6 no permission", 35'h0_0000_4000, 1'b0, 11'h0,
          64'hC000_0000_0000_4800, 1'b1, 2);
    t_ack();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule